// File: doc/BRIEF.md
# Video Timing Attribute Packet Inserter

This block places one attribute packet per video frame into the symbol stream of a multi-lane display link. The packet carries the stream's timing and format description: the 24-bit link-to-pixel clock ratio terms, eight 16-bit raster timing values, the sync polarities, and the colour format flags. It is sent while vertical blanking is active, as an in-band data packet framed by control (K) symbols. The whole packet shares one symbol slot grid across all active lanes, and its 24 payload bytes are spread over the lanes.

A blanking scheduler drives `slot_free` high on the cycles that the inserter may take. On every other cycle, and whenever no packet is due, the incoming lane symbols pass through unchanged after one register stage. A packet is armed when the blanking indicator rises. If that rise comes while an earlier packet is still being sent, the new frame gets no packet. If the window closes before any slot is granted, the packet is dropped.

Top module: `msa_inserter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dout` and `kout` are all zero and no packet is in progress.
- R2: On any cycle that does not emit a packet symbol, `dout`/`kout` equal `din`/`kin` from the previous cycle.
- R3: A packet consists of, on every lane in the same slot, two start symbols (0x5C with K=1), then the payload slots (K=0), then one end symbol (0xFD with K=1). Its total length is 3 + 24/LANES slots.
- R4: The 24 payload bytes are, in order: M, N (3 bytes each), then H total, V total, H start, V start, H sync width, V sync width, H active, V active (2 bytes each). Every multi-byte field is sent most significant byte first.
- R5: Payload byte 22 is {hsync active-low, vsync active-low, synchronous clock, YCC-not-RGB, 4:2:2-not-4:4:4, reduced range, interlaced-even, 0} from bit 7 down to bit 0. Byte 23 is {colour depth[2:0], 3D mode[1:0], 000}. Depth 001 means 8 bits per component, and 3D mode 00 means none.
- R6: Payload byte i goes on lane i mod LANES, in payload slot i / LANES (packet slot 2 + i / LANES).
- R7: A packet is armed only by a rising edge of `vblank`. The first symbol leaves on the first cycle after that edge on which both `slot_free` and `vblank` are high, and a window yields at most one packet.
- R8: Packet symbols advance only on cycles with `slot_free` high. A low cycle passes the input through and the packet resumes at the next symbol.
- R9: If `vblank` rises while a packet is still being sent (its end symbol included), that frame gets no packet. The next window is served normally.
- R10: If `vblank` falls before the armed packet has started, the packet is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank | input | 1 | Vertical blanking window indicator |
| slot_free | input | 1 | Scheduler grants this cycle's slot to the inserter |
| din | input | LANES*8 | Incoming symbols, lane l at bits l*8+:8 |
| kin | input | LANES | Incoming K flags, one per lane |
| m_val | input | 24 | Clock ratio numerator |
| n_val | input | 24 | Clock ratio denominator |
| h_total | input | 16 | Total pixels per line |
| v_total | input | 16 | Total lines per frame |
| h_start | input | 16 | Pixels from sync start to active start |
| v_start | input | 16 | Lines from sync start to active start |
| h_sync_w | input | 16 | Horizontal sync width |
| v_sync_w | input | 16 | Vertical sync width |
| h_active | input | 16 | Active pixels per line |
| v_active | input | 16 | Active lines per frame |
| hsync_low | input | 1 | Horizontal sync is active low |
| vsync_low | input | 1 | Vertical sync is active low |
| sync_clk | input | 1 | Link and pixel clocks are synchronous |
| ycc_fmt | input | 1 | YCC colour rather than RGB |
| sub422 | input | 1 | 4:2:2 sampling rather than 4:4:4 |
| range_red | input | 1 | Reduced quantisation range |
| ilace_even | input | 1 | Interlaced with even field count |
| depth_code | input | 3 | Colour depth code |
| stereo_mode | input | 2 | 3D mode code |
| dout | output | LANES*8 | Outgoing symbols |
| kout | output | LANES | Outgoing K flags |

## Verification
The window opening and the sending of a packet can fall in the same cycle. The rising edge of `vblank` then lands on a cycle when a symbol of the previous packet, such as a stalled one, is still due. The bench holds `slot_free` low to stretch a packet across a full blanking gap, then opens a new window. It judges the result by the packet finishing on schedule and by no second start pair appearing for the rest of that window. A later window must still produce a complete packet.

// File: rtl/msa_pkg.sv
package msa_pkg;
  localparam int          MSA_BYTES = 24;
  localparam logic [7:0]  K_SS      = 8'h5C;
  localparam logic [7:0]  K_SE      = 8'hFD;

  // index of the end-framing slot for a given lane count
  function automatic int pkt_last(input int lanes);
    return 2 + MSA_BYTES / lanes;
  endfunction

  // payload byte carried by a lane in a given packet slot
  function automatic int payload_index(input int slot, input int lanes, input int lane);
    return (slot - 2) * lanes + lane;
  endfunction
endpackage

// File: rtl/msa_field_packer.sv
module msa_field_packer
  import msa_pkg::*;
(
  input  logic [23:0] m_val,
  input  logic [23:0] n_val,
  input  logic [15:0] h_total,
  input  logic [15:0] v_total,
  input  logic [15:0] h_start,
  input  logic [15:0] v_start,
  input  logic [15:0] h_sync_w,
  input  logic [15:0] v_sync_w,
  input  logic [15:0] h_active,
  input  logic [15:0] v_active,
  input  logic        hsync_low,
  input  logic        vsync_low,
  input  logic        sync_clk,
  input  logic        ycc_fmt,
  input  logic        sub422,
  input  logic        range_red,
  input  logic        ilace_even,
  input  logic [2:0]  depth_code,
  input  logic [1:0]  stereo_mode,
  output logic [MSA_BYTES-1:0][7:0] bytes_o
);
  logic [7:0] flag_a, flag_b;

  assign flag_a = {hsync_low, vsync_low, sync_clk, ycc_fmt, sub422, range_red, ilace_even, 1'b0};
  assign flag_b = {depth_code, stereo_mode, 3'b000};

  always_comb begin
    bytes_o[0]  = m_val[23:16];
    bytes_o[1]  = m_val[15:8];
    bytes_o[2]  = m_val[7:0];
    bytes_o[3]  = n_val[23:16];
    bytes_o[4]  = n_val[15:8];
    bytes_o[5]  = n_val[7:0];
    bytes_o[6]  = h_total[15:8];
    bytes_o[7]  = h_total[7:0];
    bytes_o[8]  = v_total[15:8];
    bytes_o[9]  = v_total[7:0];
    bytes_o[10] = h_start[15:8];
    bytes_o[11] = h_start[7:0];
    bytes_o[12] = v_start[15:8];
    bytes_o[13] = v_start[7:0];
    bytes_o[14] = h_sync_w[15:8];
    bytes_o[15] = h_sync_w[7:0];
    bytes_o[16] = v_sync_w[15:8];
    bytes_o[17] = v_sync_w[7:0];
    bytes_o[18] = h_active[15:8];
    bytes_o[19] = h_active[7:0];
    bytes_o[20] = v_active[15:8];
    bytes_o[21] = v_active[7:0];
    bytes_o[22] = flag_a;
    bytes_o[23] = flag_b;
  end
endmodule

// File: rtl/msa_sequencer.sv
module msa_sequencer #(
  parameter int LAST = 8,
  localparam int IDXW = $clog2(LAST + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vblank,
  input  logic            slot_free,
  output logic            go,
  output logic [IDXW-1:0] idx_eff,
  output logic            ev_start,
  output logic            ev_end,
  output logic            ev_defer,
  output logic            sending,
  output logic            pending
);
  logic            vblank_q;
  logic [IDXW-1:0] idx_q;
  logic            vblank_rise;

  assign vblank_rise = vblank && !vblank_q;
  assign idx_eff     = sending ? idx_q : '0;
  assign go          = slot_free && (sending || (pending && vblank));
  assign ev_start    = go && !sending;
  assign ev_end      = go && (idx_eff == IDXW'(LAST));
  assign ev_defer    = vblank_rise && sending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vblank_q <= 1'b0;
      pending  <= 1'b0;
      sending  <= 1'b0;
      idx_q    <= '0;
    end else begin
      vblank_q <= vblank;
      if (go)
        pending <= 1'b0;
      else if (!vblank)
        pending <= 1'b0;
      else if (vblank_rise)
        pending <= !sending;
      if (go) begin
        if (ev_end) begin
          sending <= 1'b0;
          idx_q   <= '0;
        end else begin
          sending <= 1'b1;
          idx_q   <= idx_eff + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/msa_lane_mux.sv
module msa_lane_mux
  import msa_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LANE  = 0,
  localparam int LAST = pkt_last(LANES),
  localparam int IDXW = $clog2(LAST + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go,
  input  logic [IDXW-1:0]           idx_eff,
  input  logic [MSA_BYTES-1:0][7:0] bytes_i,
  input  logic [7:0]                din_l,
  input  logic                      kin_l,
  output logic [7:0]                dout_l,
  output logic                      kout_l
);
  logic [7:0] sym;
  logic       sym_k;
  int         bidx;

  always_comb begin
    bidx  = 0;
    sym   = K_SS;
    sym_k = 1'b1;
    if (int'(idx_eff) == LAST) begin
      sym = K_SE;
    end else if (int'(idx_eff) >= 2) begin
      bidx  = payload_index(int'(idx_eff), LANES, LANE) % MSA_BYTES;
      sym   = bytes_i[bidx];
      sym_k = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_l <= '0;
      kout_l <= 1'b0;
    end else if (go) begin
      dout_l <= sym;
      kout_l <= sym_k;
    end else begin
      dout_l <= din_l;
      kout_l <= kin_l;
    end
  end
endmodule

// File: rtl/msa_inserter.sv
module msa_inserter
  import msa_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vblank,
  input  logic               slot_free,
  input  logic [LANES*8-1:0] din,
  input  logic [LANES-1:0]   kin,
  input  logic [23:0]        m_val,
  input  logic [23:0]        n_val,
  input  logic [15:0]        h_total,
  input  logic [15:0]        v_total,
  input  logic [15:0]        h_start,
  input  logic [15:0]        v_start,
  input  logic [15:0]        h_sync_w,
  input  logic [15:0]        v_sync_w,
  input  logic [15:0]        h_active,
  input  logic [15:0]        v_active,
  input  logic               hsync_low,
  input  logic               vsync_low,
  input  logic               sync_clk,
  input  logic               ycc_fmt,
  input  logic               sub422,
  input  logic               range_red,
  input  logic               ilace_even,
  input  logic [2:0]         depth_code,
  input  logic [1:0]         stereo_mode,
  output logic [LANES*8-1:0] dout,
  output logic [LANES-1:0]   kout
);
  localparam int LAST = pkt_last(LANES);
  localparam int IDXW = $clog2(LAST + 1);

  logic [MSA_BYTES-1:0][7:0] pkt_bytes;
  logic                      go, ev_start, ev_end, ev_defer, sending, pending;
  logic [IDXW-1:0]           idx_eff;

  msa_field_packer u_pack (
    .m_val(m_val), .n_val(n_val), .h_total(h_total), .v_total(v_total),
    .h_start(h_start), .v_start(v_start), .h_sync_w(h_sync_w), .v_sync_w(v_sync_w),
    .h_active(h_active), .v_active(v_active), .hsync_low(hsync_low),
    .vsync_low(vsync_low), .sync_clk(sync_clk), .ycc_fmt(ycc_fmt), .sub422(sub422),
    .range_red(range_red), .ilace_even(ilace_even), .depth_code(depth_code),
    .stereo_mode(stereo_mode), .bytes_o(pkt_bytes)
  );

  msa_sequencer #(.LAST(LAST)) u_seq (
    .clk(clk), .rst_n(rst_n), .vblank(vblank), .slot_free(slot_free),
    .go(go), .idx_eff(idx_eff), .ev_start(ev_start), .ev_end(ev_end),
    .ev_defer(ev_defer), .sending(sending), .pending(pending)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    msa_lane_mux #(.LANES(LANES), .LANE(l)) u_mux (
      .clk(clk), .rst_n(rst_n), .go(go), .idx_eff(idx_eff), .bytes_i(pkt_bytes),
      .din_l(din[l*8 +: 8]), .kin_l(kin[l]),
      .dout_l(dout[l*8 +: 8]), .kout_l(kout[l])
    );
  end
endmodule

// File: rtl/msa_inserter_chk.sv
module msa_inserter_chk
  import msa_pkg::*;
#(
  parameter int LANES = 4,
  parameter int IDXW  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vblank,
  input logic               slot_free,
  input logic [LANES*8-1:0] din,
  input logic [LANES-1:0]   kin,
  input logic [LANES*8-1:0] dout,
  input logic [LANES-1:0]   kout,
  input logic               go,
  input logic [IDXW-1:0]    idx_eff,
  input logic               ev_start,
  input logic               ev_end,
  input logic               ev_defer,
  input logic               sending,
  input logic               pending
);
  p_start_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> (vblank && pending && slot_free));

  p_open_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (kout == '1 && dout == {LANES{K_SS}}));

  p_close_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> (kout == '1 && dout == {LANES{K_SE}}));

  p_passthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (dout == $past(din) && kout == $past(kin)));

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && !slot_free) |=> (sending && $stable(idx_eff)));

  p_defer_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_defer |=> !pending);

  p_close_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vblank && !go) |=> !pending);
endmodule

bind msa_inserter msa_inserter_chk #(.LANES(LANES), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vblank(vblank), .slot_free(slot_free),
  .din(din), .kin(kin), .dout(dout), .kout(kout), .go(go), .idx_eff(idx_eff),
  .ev_start(ev_start), .ev_end(ev_end), .ev_defer(ev_defer),
  .sending(sending), .pending(pending)
);

// File: tb/msa_inserter_tb.sv
module msa_inserter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L    = 4;
  localparam int LAST = 2 + 24 / L;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vblank = 1'b0, slot_free = 1'b0;
  logic [L*8-1:0] din = '0, last_din = '0;
  logic [L-1:0]   kin = '0, last_kin = '0;
  logic [23:0] m_val, n_val;
  logic [15:0] h_total, v_total, h_start, v_start, h_sync_w, v_sync_w, h_active, v_active;
  logic hsync_low, vsync_low, sync_clk, ycc_fmt, sub422, range_red, ilace_even;
  logic [2:0] depth_code;
  logic [1:0] stereo_mode;
  logic [L*8-1:0] dout;
  logic [L-1:0]   kout;
  int checks = 0, errors = 0;
  int cnt = 0;
  logic [191:0] exp_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  msa_inserter #(.LANES(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .vblank(vblank), .slot_free(slot_free),
    .din(din), .kin(kin), .m_val(m_val), .n_val(n_val), .h_total(h_total),
    .v_total(v_total), .h_start(h_start), .v_start(v_start), .h_sync_w(h_sync_w),
    .v_sync_w(v_sync_w), .h_active(h_active), .v_active(v_active),
    .hsync_low(hsync_low), .vsync_low(vsync_low), .sync_clk(sync_clk),
    .ycc_fmt(ycc_fmt), .sub422(sub422), .range_red(range_red),
    .ilace_even(ilace_even), .depth_code(depth_code), .stereo_mode(stereo_mode),
    .dout(dout), .kout(kout)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    return exp_vec[191 - 8*i -: 8];
  endfunction

  function automatic void build_expected();
    exp_vec = {m_val, n_val, h_total, v_total, h_start, v_start, h_sync_w, v_sync_w,
               h_active, v_active,
               hsync_low, vsync_low, sync_clk, ycc_fmt, sub422, range_red, ilace_even, 1'b0,
               depth_code, stereo_mode, 3'b000};
  endfunction

  // drive one cycle of inputs, wait until its result is visible
  task automatic cyc(input logic vb, input logic sf);
    cnt++;
    vblank    = vb;
    slot_free = sf;
    for (int l = 0; l < L; l++) din[l*8 +: 8] = 8'(cnt * 7 + l * 16);
    kin      = L'(cnt);
    last_din = din;
    last_kin = kin;
    @(negedge clk);
  endtask

  task automatic expect_pass(input string req);
    check(req, 64'(dout), 64'(last_din));
    check(req, 64'(kout), 64'(last_kin));
  endtask

  task automatic expect_slot(input string req, input int s);
    for (int l = 0; l < L; l++) begin
      if (s < 2) begin
        check(req, {55'd0, kout[l], dout[l*8 +: 8]}, {55'd0, 1'b1, 8'h5C});
      end else if (s == LAST) begin
        check(req, {55'd0, kout[l], dout[l*8 +: 8]}, {55'd0, 1'b1, 8'hFD});
      end else begin
        check(req, {55'd0, kout[l], dout[l*8 +: 8]}, {55'd0, 1'b0, exp_byte((s - 2) * L + l)});
      end
    end
  endtask

  task automatic run_packet(input string req);
    build_expected();
    cyc(1, 1); expect_pass({req, " arm cycle R7"});
    for (int s = 0; s <= LAST; s++) begin
      cyc(1, 1); expect_slot({req, " R3 R6"}, s);
    end
    for (int i = 0; i < 6; i++) begin
      cyc(1, 1); expect_pass({req, " one per window R7"});
    end
    cyc(0, 1); expect_pass({req, " window closed R2"});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset dout", 64'(dout), 64'd0);
    check("R1 reset kout", 64'(kout), 64'd0);
    rst_n = 1'b1;
    cyc(0, 0); expect_pass("R1 after reset");
  endtask

  task automatic t_passthrough();
    for (int i = 0; i < 4; i++) begin
      cyc(0, i[0]); expect_pass("R2 passthrough");
    end
  endtask

  task automatic t_example_fields();
    m_val = 24'd77672; n_val = 24'd524288;
    h_total = 16'd1056; v_total = 16'd628; h_start = 16'd216; v_start = 16'd27;
    h_sync_w = 16'd128; v_sync_w = 16'd4; h_active = 16'd800; v_active = 16'd600;
    hsync_low = 0; vsync_low = 0; sync_clk = 1; ycc_fmt = 0; sub422 = 0;
    range_red = 0; ilace_even = 0; depth_code = 3'b001; stereo_mode = 2'b00;
    build_expected();
    check("R4 M msb", 64'(exp_byte(0)), 64'h01);
    check("R4 N msb", 64'(exp_byte(3)), 64'h08);
    check("R5 flags", 64'(exp_byte(22)), 64'h20);
    check("R5 depth", 64'(exp_byte(23)), 64'h20);
    run_packet("R4 R5 example");
  endtask

  task automatic t_flag_fields();
    m_val = 24'hA1B2C3; n_val = 24'h0D0E0F;
    h_total = 16'h1234; v_total = 16'h5678; h_start = 16'h9ABC; v_start = 16'hDEF0;
    h_sync_w = 16'h0102; v_sync_w = 16'h0304; h_active = 16'h0506; v_active = 16'h0708;
    hsync_low = 1; vsync_low = 0; sync_clk = 1; ycc_fmt = 0; sub422 = 1;
    range_red = 0; ilace_even = 1; depth_code = 3'b100; stereo_mode = 2'b01;
    build_expected();
    check("R5 flags alt", 64'(exp_byte(22)), 64'hAA);
    check("R5 depth alt", 64'(exp_byte(23)), 64'h88);
    run_packet("R4 R5 R6 alt");
  endtask

  task automatic t_gating();
    int s = 0;
    build_expected();
    cyc(1, 1); expect_pass("R8 arm");
    for (int i = 0; s <= LAST && i < 60; i++) begin
      if (i % 3 == 1) begin
        cyc(1, 0); expect_pass("R8 stalled cycle passes input");
      end else begin
        cyc(1, 1); expect_slot("R8 resumed symbol", s);
        s++;
      end
    end
    cyc(1, 1); expect_pass("R8 after packet");
    cyc(0, 1); expect_pass("R8 close");
  endtask

  task automatic t_defer();
    build_expected();
    cyc(1, 1); expect_pass("R9 arm");
    cyc(1, 1); expect_slot("R9 first start", 0);
    cyc(1, 0); expect_pass("R9 stall");
    cyc(0, 0); expect_pass("R9 window gap");
    cyc(1, 0); expect_pass("R9 window opens during packet");
    for (int s = 1; s <= LAST; s++) begin
      cyc(1, 1); expect_slot("R9 packet completes", s);
    end
    for (int i = 0; i < 8; i++) begin
      cyc(1, 1); expect_pass("R9 deferred frame has no packet");
    end
    cyc(0, 1); expect_pass("R9 close");
    run_packet("R9 next window served");
  endtask

  task automatic t_close_early();
    cyc(1, 0); expect_pass("R10 arm without slot");
    cyc(1, 0); expect_pass("R10 wait");
    cyc(0, 0); expect_pass("R10 window closes");
    for (int i = 0; i < 5; i++) begin
      cyc(0, 1); expect_pass("R10 dropped packet");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_passthrough();
    t_example_fields();
    t_flag_fields();
    t_gating();
    t_defer();
    t_close_early();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule